// File: doc/BRIEF.md
# Compressed instruction expander

This block sits in the decode stage of a 32-bit core that supports the 16-bit compressed instruction set. It receives one halfword that fetch has already aligned. In the same cycle it returns the equivalent full-length base instruction word, plus a flag that marks the halfword as illegal. The block is purely combinational and holds no state.

The decoder covers three groups of encodings, chosen by the low two bits. The first group holds stack-pointer-scaled additions and word memory accesses through compact registers. The second holds immediate arithmetic, upper-immediate loads, shifts, register-register logic, jumps and zero-compare branches. The third holds stack-relative word accesses, left shifts, moves, adds, indirect jumps and the breakpoint. Each format scatters its immediate bits in its own order, and the block gathers them back. A 3-bit compact register field selects one of registers x8 to x15. When the flag is raised, the word output is forced to zero, so a later stage has a single known value to trap on.

Top module: `cexp_expander`

## Requirements
- R1: An all-zero halfword, or any halfword whose bits [1:0] equal 11, sets illegal_o. Whenever illegal_o is 1, instr_o is 32'h0. Whenever illegal_o is 0, instr_o[1:0] is 11.
- R2: Group 00 with bits [15:13]=000 expands to ADDI rd, x2, uimm. Here rd = x(8+bits[4:2]). The unsigned immediate is built as uimm[9:6]=bits[10:7], uimm[5:4]=bits[12:11], uimm[3]=bit 5, uimm[2]=bit 6, and uimm[1:0]=0. A zero immediate is illegal.
- R3: Group 00 with bits [15:13]=010 expands to LW, and with 110 expands to SW, both at width code 010. The offset is zero-extended and built as off[6]=bit 5, off[5:3]=bits[12:10], off[2]=bit 6, off[1:0]=0. The base register is x(8+bits[9:7]). The data register is x(8+bits[4:2]).
- R4: Group 01 with bits [15:13]=000 expands to ADDI rd, rd, simm6. With 010 it expands to ADDI rd, x0, simm6. In both cases simm6={bit12, bits[6:2]} is sign-extended and rd=bits[11:7].
- R5: Group 01 with bits [15:13]=011 and rd=2 expands to ADDI x2, x2, imm. The immediate is sign-extended and built as imm[9]=bit 12, imm[8:7]=bits[4:3], imm[6]=bit 5, imm[5]=bit 2, imm[4]=bit 6, imm[3:0]=0. A zero immediate is illegal.
- R6: Group 01 with bits [15:13]=011 and rd other than 2 expands to LUI rd. The 6-bit field {bit12, bits[6:2]} is placed in result bits 17:12 and sign-extended from bit 17. A zero field is illegal.
- R7: Right shifts (group 01, 100, bits[11:10]=00 for logical and 01 for arithmetic, register x(8+bits[9:7])) and left shifts (group 10, 000, rd=bits[11:7]) use shift amount bits[6:2]. A zero shift amount is illegal. Bit 12 set is illegal.
- R8: Group 01, 100, bits[11:10]=10 expands to ANDI with a sign-extended 6-bit immediate applied to x(8+bits[9:7]).
- R9: Group 01, 100, bits[11:10]=11 with bit 12 = 0 expands to a register-register op. Bits[6:5] select it: 00 gives SUB, 01 XOR, 10 OR, 11 AND. The destination is x(8+bits[9:7]) and the second source is x(8+bits[4:2]). Bit 12 = 1 is illegal.
- R10: Group 01, bits[15:13]=001 expands to JAL x1, and 101 expands to JAL x0. The 12-bit signed even offset is built as off[11]=bit12, off[10]=bit8, off[9:8]=bits[10:9], off[7]=bit6, off[6]=bit7, off[5]=bit2, off[4]=bit11, off[3:1]=bits[5:3].
- R11: Group 01, 110 expands to BEQ, and 111 expands to BNE. Both compare x(8+bits[9:7]) against x0. The 9-bit signed even offset is built as off[8]=bit12, off[7:6]=bits[6:5], off[5]=bit2, off[4:3]=bits[11:10], off[2:1]=bits[4:3].
- R12: Group 10, 010 expands to LW rd, off(x2), and 110 expands to SW rs2, off(x2). The load offset is built as off[7:6]=bits[3:2], off[5]=bit12, off[4:2]=bits[6:4]. The store offset is built as off[7:6]=bits[8:7], off[5:2]=bits[12:9]. A load with rd=0 is illegal.
- R13: Group 10, 100 depends on bit 12 and the two register fields. Bit12=0 with rs2=0 gives JALR x0, 0(rs1), and rs1=0 in that case is illegal. Bit12=0 with rs2 nonzero gives ADD rd, x0, rs2. Bit12=1 with rs1=0 and rs2=0 gives EBREAK (32'h00100073). Bit12=1 with rs2=0 and rs1 nonzero gives JALR x1, 0(rs1). Bit12=1 with rs2 nonzero gives ADD rd, rd, rs2.
- R14: The following are illegal: group 00 with bits [15:13] of 001, 011, 100, 101 or 111, and group 10 with bits [15:13] of 001, 011, 101 or 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Compressed halfword from fetch |
| instr_o | output | 32 | Expanded base instruction, zero when illegal |
| illegal_o | output | 1 | Halfword has no legal expansion |

## Verification
Both outputs are combinational, so each result is due zero cycles after its stimulus and is valid in the same cycle the halfword is presented. The bench applies each halfword at a falling clock edge and compares both outputs at the following rising edge. That leaves half a period for the result to settle and keeps the comparison away from the moment the input changes. The expected words come from an operand-level encoder in the bench. It scatters chosen operands into the compressed layout and separately assembles the full-length word from the same operands.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int unsigned CW = 16;
  localparam int unsigned IW = 32;
  localparam int unsigned RW = 5;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [IW-1:0] WORD_EBREAK = 32'h0010_0073;

  // compact 3-bit register field -> x8..x15
  function automatic logic [RW-1:0] creg(input logic [2:0] r);
    return {2'b01, r};
  endfunction

  function automatic logic [IW-1:0] enc_i(input logic [11:0] imm, input logic [RW-1:0] rs1,
                                          input logic [2:0] f3, input logic [RW-1:0] rd,
                                          input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [IW-1:0] enc_s(input logic [11:0] imm, input logic [RW-1:0] rs2,
                                          input logic [RW-1:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [IW-1:0] enc_r(input logic [6:0] f7, input logic [RW-1:0] rs2,
                                          input logic [RW-1:0] rs1, input logic [2:0] f3,
                                          input logic [RW-1:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction

  function automatic logic [IW-1:0] enc_b(input logic [12:0] imm, input logic [RW-1:0] rs1,
                                          input logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [IW-1:0] enc_j(input logic [20:0] imm, input logic [RW-1:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction
endpackage

// File: rtl/cexp_q0.sv
module cexp_q0
  import cexp_pkg::*;
(
  input  logic [CW-1:2] instr_i,
  output logic [IW-1:0] instr_o,
  output logic          illegal_o
);
  logic [9:0] spn_imm;
  logic [6:0] mem_off;

  assign spn_imm = {instr_i[10:7], instr_i[12:11], instr_i[5], instr_i[6], 2'b00};
  assign mem_off = {instr_i[5], instr_i[12:10], instr_i[6], 2'b00};

  always_comb begin
    instr_o   = '0;
    illegal_o = 1'b0;
    unique case (instr_i[15:13])
      3'b000: begin
        instr_o   = enc_i({2'b00, spn_imm}, 5'd2, 3'b000, creg(instr_i[4:2]), OPC_OPIMM);
        illegal_o = (spn_imm == '0);
      end
      3'b010: instr_o = enc_i({5'd0, mem_off}, creg(instr_i[9:7]), 3'b010,
                              creg(instr_i[4:2]), OPC_LOAD);
      3'b110: instr_o = enc_s({5'd0, mem_off}, creg(instr_i[4:2]), creg(instr_i[9:7]), 3'b010);
      default: illegal_o = 1'b1;  // FP forms and reserved slot
    endcase
  end
endmodule

// File: rtl/cexp_q1.sv
module cexp_q1
  import cexp_pkg::*;
(
  input  logic [CW-1:2] instr_i,
  output logic [IW-1:0] instr_o,
  output logic          illegal_o
);
  logic [RW-1:0] rd, rdc, rs2c;
  logic [11:0]   imm6_sx, sp_imm, jmp_off;
  logic [12:0]   br_off;
  logic [19:0]   up_imm;
  logic [4:0]    shamt;
  logic          nz6;

  assign rd      = instr_i[11:7];
  assign rdc     = creg(instr_i[9:7]);
  assign rs2c    = creg(instr_i[4:2]);
  assign shamt   = instr_i[6:2];
  assign nz6     = instr_i[12] | (shamt != '0);
  assign imm6_sx = {{6{instr_i[12]}}, instr_i[12], instr_i[6:2]};
  assign sp_imm  = {{2{instr_i[12]}}, instr_i[12], instr_i[4:3], instr_i[5], instr_i[2],
                    instr_i[6], 4'b0000};
  assign up_imm  = {{14{instr_i[12]}}, instr_i[12], instr_i[6:2]};
  assign jmp_off = {instr_i[12], instr_i[8], instr_i[10:9], instr_i[6], instr_i[7],
                    instr_i[2], instr_i[11], instr_i[5:3], 1'b0};
  assign br_off  = {{4{instr_i[12]}}, instr_i[12], instr_i[6:5], instr_i[2], instr_i[11:10],
                    instr_i[4:3], 1'b0};

  always_comb begin
    instr_o   = '0;
    illegal_o = 1'b0;
    unique case (instr_i[15:13])
      3'b000: instr_o = enc_i(imm6_sx, rd, 3'b000, rd, OPC_OPIMM);
      3'b001: instr_o = enc_j({{9{jmp_off[11]}}, jmp_off}, 5'd1);
      3'b010: instr_o = enc_i(imm6_sx, 5'd0, 3'b000, rd, OPC_OPIMM);
      3'b011: begin
        illegal_o = !nz6;
        if (rd == 5'd2) instr_o = enc_i(sp_imm, 5'd2, 3'b000, 5'd2, OPC_OPIMM);
        else            instr_o = {up_imm, rd, OPC_LUI};
      end
      3'b100: begin
        unique case (instr_i[11:10])
          2'b00: begin
            instr_o   = enc_i({7'b0000000, shamt}, rdc, 3'b101, rdc, OPC_OPIMM);
            illegal_o = instr_i[12] | (shamt == '0);
          end
          2'b01: begin
            instr_o   = enc_i({7'b0100000, shamt}, rdc, 3'b101, rdc, OPC_OPIMM);
            illegal_o = instr_i[12] | (shamt == '0);
          end
          2'b10: instr_o = enc_i(imm6_sx, rdc, 3'b111, rdc, OPC_OPIMM);
          default: begin
            illegal_o = instr_i[12];  // 64-bit word ops / reserved
            unique case (instr_i[6:5])
              2'b00:   instr_o = enc_r(7'b0100000, rs2c, rdc, 3'b000, rdc);
              2'b01:   instr_o = enc_r(7'b0000000, rs2c, rdc, 3'b100, rdc);
              2'b10:   instr_o = enc_r(7'b0000000, rs2c, rdc, 3'b110, rdc);
              default: instr_o = enc_r(7'b0000000, rs2c, rdc, 3'b111, rdc);
            endcase
          end
        endcase
      end
      3'b101: instr_o = enc_j({{9{jmp_off[11]}}, jmp_off}, 5'd0);
      3'b110: instr_o = enc_b(br_off, rdc, 3'b000);
      default: instr_o = enc_b(br_off, rdc, 3'b001);
    endcase
  end
endmodule

// File: rtl/cexp_q2.sv
module cexp_q2
  import cexp_pkg::*;
(
  input  logic [CW-1:2] instr_i,
  output logic [IW-1:0] instr_o,
  output logic          illegal_o
);
  logic [RW-1:0] rs1, rs2;
  logic [7:0]    ld_off, st_off;

  assign rs1    = instr_i[11:7];
  assign rs2    = instr_i[6:2];
  assign ld_off = {instr_i[3:2], instr_i[12], instr_i[6:4], 2'b00};
  assign st_off = {instr_i[8:7], instr_i[12:9], 2'b00};

  always_comb begin
    instr_o   = '0;
    illegal_o = 1'b0;
    unique case (instr_i[15:13])
      3'b000: begin
        instr_o   = enc_i({7'b0000000, rs2}, rs1, 3'b001, rs1, OPC_OPIMM);
        illegal_o = instr_i[12] | (rs2 == '0);
      end
      3'b010: begin
        instr_o   = enc_i({4'd0, ld_off}, 5'd2, 3'b010, rs1, OPC_LOAD);
        illegal_o = (rs1 == '0);
      end
      3'b100: begin
        if (!instr_i[12]) begin
          if (rs2 == '0) begin
            instr_o   = enc_i(12'd0, rs1, 3'b000, 5'd0, OPC_JALR);
            illegal_o = (rs1 == '0);
          end else begin
            instr_o = enc_r(7'd0, rs2, 5'd0, 3'b000, rs1);
          end
        end else if (rs2 == '0) begin
          if (rs1 == '0) instr_o = WORD_EBREAK;
          else           instr_o = enc_i(12'd0, rs1, 3'b000, 5'd1, OPC_JALR);
        end else begin
          instr_o = enc_r(7'd0, rs2, rs1, 3'b000, rs1);
        end
      end
      3'b110: instr_o = enc_s({4'd0, st_off}, rs2, 5'd2, 3'b010);
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cexp_expander.sv
module cexp_expander
  import cexp_pkg::*;
(
  input  logic [CW-1:0] instr_i,
  output logic [IW-1:0] instr_o,
  output logic          illegal_o
);
  localparam int unsigned NQ = 3;

  logic [IW-1:0] q_word [NQ];
  logic [NQ-1:0] q_ill;
  logic [IW-1:0] sel_word;
  logic          sel_ill;

  cexp_q0 u_q0 (.instr_i(instr_i[CW-1:2]), .instr_o(q_word[0]), .illegal_o(q_ill[0]));
  cexp_q1 u_q1 (.instr_i(instr_i[CW-1:2]), .instr_o(q_word[1]), .illegal_o(q_ill[1]));
  cexp_q2 u_q2 (.instr_i(instr_i[CW-1:2]), .instr_o(q_word[2]), .illegal_o(q_ill[2]));

  always_comb begin
    sel_word = '0;
    sel_ill  = 1'b1;  // quadrant 11 is not a compressed encoding
    for (int q = 0; q < NQ; q++) begin
      if (instr_i[1:0] == 2'(q)) begin
        sel_word = q_word[q];
        sel_ill  = q_ill[q];
      end
    end
  end

  assign illegal_o = sel_ill;
  assign instr_o   = sel_ill ? '0 : sel_word;
endmodule

// File: rtl/cexp_checker.sv
module cexp_checker
  import cexp_pkg::*;
(
  input logic [CW-1:0] instr_i,
  input logic [IW-1:0] instr_o,
  input logic          illegal_o
);
  always_comb begin
    if (instr_i == '0) AST_ZERO_HALFWORD: assert (illegal_o);                         // R1
    if (instr_i[1:0] == 2'b11) AST_NOT_COMPRESSED: assert (illegal_o);                // R1
    if (illegal_o) AST_ILLEGAL_ZERO_WORD: assert (instr_o == '0);                     // R1
    if (!illegal_o) AST_FULL_LENGTH: assert (instr_o[1:0] == 2'b11);                  // R1
    if (!illegal_o && instr_i[1:0] == 2'b01 && instr_i[15:14] == 2'b11)
      AST_BRANCH_VS_X0: assert (instr_o[6:0] == OPC_BRANCH && instr_o[24:20] == 5'd0); // R11
    if (!illegal_o && instr_i[1:0] == 2'b01 && instr_i[15:13] == 3'b001)
      AST_LINK_X1: assert (instr_o[6:0] == OPC_JAL && instr_o[11:7] == 5'd1);         // R10
    if (!illegal_o && instr_o[6:0] == OPC_OPIMM && instr_o[13:12] == 2'b01)
      AST_SHAMT_NONZERO: assert (instr_o[24:20] != 5'd0 && instr_o[25] == 1'b0);      // R7
    if (!illegal_o && instr_i[1:0] == 2'b10 && instr_i[15:13] == 3'b010)
      AST_STACK_LOAD_RD: assert (instr_o[11:7] != 5'd0 && instr_o[19:15] == 5'd2);    // R12
  end
endmodule

bind cexp_expander cexp_checker u_cexp_checker (
  .instr_i  (instr_i),
  .instr_o  (instr_o),
  .illegal_o(illegal_o)
);

// File: tb/tb_cexp_expander.sv
module tb_cexp_expander;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] LD = 7'b0000011, ST = 7'b0100011, OI = 7'b0010011, OP = 7'b0110011;
  localparam logic [6:0] LU = 7'b0110111, BR = 7'b1100011, JL = 7'b1101111, JR = 7'b1100111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] c_in = 16'h0;
  logic [31:0] w_out;
  logic        ill_out;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  logic [15:0] q_c[$];
  logic [31:0] q_w[$];
  bit          q_i[$];
  string       q_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cexp_expander dut (.instr_i(c_in), .instr_o(w_out), .illegal_o(ill_out));

  // full-length assemblers
  function automatic logic [31:0] ri(int imm, int rs1, logic [2:0] f3, int rd, logic [6:0] op);
    logic [11:0] i = 12'(imm);
    return {i, 5'(rs1), f3, 5'(rd), op};
  endfunction
  function automatic logic [31:0] rs(int imm, int rs2, int rs1);
    logic [11:0] i = 12'(imm);
    return {i[11:5], 5'(rs2), 5'(rs1), 3'b010, i[4:0], ST};
  endfunction
  function automatic logic [31:0] rr(logic [6:0] f7, int rs2, int rs1, logic [2:0] f3, int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), OP};
  endfunction
  function automatic logic [31:0] rb(int off, int rs1, logic [2:0] f3);
    logic [12:0] i = 13'(off);
    return {i[12], i[10:5], 5'd0, 5'(rs1), f3, i[4:1], i[11], BR};
  endfunction
  function automatic logic [31:0] rj(int off, int rd);
    logic [20:0] i = 21'(off);
    return {i[20], i[10:1], i[11], i[19:12], 5'(rd), JL};
  endfunction

  // compressed encoders (operands scattered into the halfword)
  function automatic logic [15:0] c_spn(int rdp, int imm);
    logic [9:0] i = 10'(imm);
    return {3'b000, i[5:4], i[9:6], i[2], i[3], 3'(rdp), 2'b00};
  endfunction
  function automatic logic [15:0] c_mem(logic [2:0] f3, int rs1p, int rp, int off);
    logic [6:0] o = 7'(off);
    return {f3, o[5:3], 3'(rs1p), o[2], o[6], 3'(rp), 2'b00};
  endfunction
  function automatic logic [15:0] c_ci(logic [2:0] f3, logic b12, int rd, logic [4:0] lo,
                                       logic [1:0] q);
    return {f3, b12, 5'(rd), lo, q};
  endfunction
  function automatic logic [15:0] c_sp16(int imm);
    logic [9:0] i = 10'(imm);
    return {3'b011, i[9], 5'd2, i[4], i[6], i[8:7], i[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_jmp(logic [2:0] f3, int off);
    logic [11:0] o = 12'(off);
    return {f3, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_br(logic [2:0] f3, int rs1p, int off);
    logic [8:0] o = 9'(off);
    return {f3, o[8], o[4:3], 3'(rs1p), o[7:6], o[2:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_ar(logic b12, logic [1:0] f2, int rdp, logic [4:0] lo);
    return {3'b100, b12, f2, 3'(rdp), lo, 2'b01};
  endfunction
  function automatic logic [15:0] c_lwsp(int rd, int off);
    logic [7:0] o = 8'(off);
    return {3'b010, o[5], 5'(rd), o[4:2], o[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] c_swsp(int rs2, int off);
    logic [7:0] o = 8'(off);
    return {3'b110, o[5:2], o[7:6], 5'(rs2), 2'b10};
  endfunction
  function automatic logic [15:0] c_cr(logic [3:0] f4, int a, int b);
    return {f4, 5'(a), 5'(b), 2'b10};
  endfunction

  task automatic put(logic [15:0] c, logic [31:0] w, bit il, string tag);
    q_c.push_back(c); q_w.push_back(il ? 32'h0 : w); q_i.push_back(il); q_t.push_back(tag);
  endtask

  initial begin
    // R1 zero pattern / not compressed
    put(16'h0000, 0, 1, "R1 all-zero");
    put(16'h4503, 0, 1, "R1 quadrant 11");
    put(16'hFFFF, 0, 1, "R1 all-ones");
    // R2
    put(c_spn(3, 1020), ri(1020, 2, 3'b000, 11, OI), 0, "R2 spn max");
    put(c_spn(0, 4), ri(4, 2, 3'b000, 8, OI), 0, "R2 spn min");
    put(c_spn(1, 0), 0, 1, "R2 spn zero");
    // R3
    put(c_mem(3'b010, 5, 2, 124), ri(124, 13, 3'b010, 10, LD), 0, "R3 lw");
    put(c_mem(3'b110, 0, 7, 68), rs(68, 15, 8), 0, "R3 sw");
    // R4
    put(c_ci(3'b000, 1'b1, 5, 5'b00000, 2'b01), ri(-32, 5, 3'b000, 5, OI), 0, "R4 addi neg");
    put(c_ci(3'b000, 1'b0, 0, 5'b00000, 2'b01), ri(0, 0, 3'b000, 0, OI), 0, "R4 nop");
    put(c_ci(3'b010, 1'b0, 31, 5'b11111, 2'b01), ri(31, 0, 3'b000, 31, OI), 0, "R4 li");
    // R5
    put(c_sp16(-512), ri(-512, 2, 3'b000, 2, OI), 0, "R5 sp adj neg");
    put(c_sp16(496), ri(496, 2, 3'b000, 2, OI), 0, "R5 sp adj pos");
    put(c_sp16(0), 0, 1, "R5 sp adj zero");
    // R6
    put(c_ci(3'b011, 1'b1, 7, 5'b00001, 2'b01), {20'hFFFE1, 5'd7, LU}, 0, "R6 lui neg");
    put(c_ci(3'b011, 1'b0, 9, 5'b00101, 2'b01), {20'h00005, 5'd9, LU}, 0, "R6 lui pos");
    put(c_ci(3'b011, 1'b0, 7, 5'b00000, 2'b01), 0, 1, "R6 lui zero");
    // R7
    put(c_ar(1'b0, 2'b00, 1, 5'd31), ri(31, 9, 3'b101, 9, OI), 0, "R7 srli");
    put(c_ar(1'b0, 2'b01, 0, 5'd1), ri(12'h401, 8, 3'b101, 8, OI), 0, "R7 srai");
    put(c_ar(1'b1, 2'b00, 1, 5'd4), 0, 1, "R7 srli bit12");
    put(c_ar(1'b0, 2'b01, 0, 5'd0), 0, 1, "R7 srai zero");
    put(c_ci(3'b000, 1'b0, 20, 5'd3, 2'b10), ri(3, 20, 3'b001, 20, OI), 0, "R7 slli");
    put(c_ci(3'b000, 1'b1, 20, 5'd3, 2'b10), 0, 1, "R7 slli bit12");
    put(c_ci(3'b000, 1'b0, 20, 5'd0, 2'b10), 0, 1, "R7 slli zero");
    // R8
    put(c_ar(1'b1, 2'b10, 4, 5'b11111), ri(-1, 12, 3'b111, 12, OI), 0, "R8 andi");
    put(c_ar(1'b0, 2'b10, 4, 5'b00101), ri(5, 12, 3'b111, 12, OI), 0, "R8 andi pos");
    // R9
    put(c_ar(1'b0, 2'b11, 0, {2'b00, 3'd7}), rr(7'h20, 15, 8, 3'b000, 8), 0, "R9 sub");
    put(c_ar(1'b0, 2'b11, 1, {2'b01, 3'd2}), rr(7'h00, 10, 9, 3'b100, 9), 0, "R9 xor");
    put(c_ar(1'b0, 2'b11, 6, {2'b10, 3'd3}), rr(7'h00, 11, 14, 3'b110, 14), 0, "R9 or");
    put(c_ar(1'b0, 2'b11, 7, {2'b11, 3'd0}), rr(7'h00, 8, 15, 3'b111, 15), 0, "R9 and");
    put(c_ar(1'b1, 2'b11, 0, 5'd0), 0, 1, "R9 bit12");
    // R10
    put(c_jmp(3'b001, -2), rj(-2, 1), 0, "R10 jal");
    put(c_jmp(3'b101, 2046), rj(2046, 0), 0, "R10 j max");
    put(c_jmp(3'b101, -2048), rj(-2048, 0), 0, "R10 j min");
    put(c_jmp(3'b001, 1364), rj(1364, 1), 0, "R10 jal mix");
    // R11
    put(c_br(3'b110, 1, -256), rb(-256, 9, 3'b000), 0, "R11 beqz");
    put(c_br(3'b111, 6, 254), rb(254, 14, 3'b001), 0, "R11 bnez");
    put(c_br(3'b110, 3, 170), rb(170, 11, 3'b000), 0, "R11 beqz mix");
    // R12
    put(c_lwsp(1, 252), ri(252, 2, 3'b010, 1, LD), 0, "R12 lwsp");
    put(c_lwsp(0, 8), 0, 1, "R12 lwsp rd0");
    put(c_swsp(31, 128), rs(128, 31, 2), 0, "R12 swsp");
    put(c_swsp(0, 124), rs(124, 0, 2), 0, "R12 swsp x0");
    // R13
    put(c_cr(4'b1000, 1, 0), ri(0, 1, 3'b000, 0, JR), 0, "R13 jr");
    put(c_cr(4'b1000, 0, 0), 0, 1, "R13 jr x0");
    put(c_cr(4'b1000, 3, 4), rr(7'h00, 4, 0, 3'b000, 3), 0, "R13 mv");
    put(c_cr(4'b1001, 0, 0), 32'h0010_0073, 0, "R13 ebreak");
    put(c_cr(4'b1001, 5, 0), ri(0, 5, 3'b000, 1, JR), 0, "R13 jalr");
    put(c_cr(4'b1001, 6, 7), rr(7'h00, 7, 6, 3'b000, 6), 0, "R13 add");
    // R14
    put(16'h2000, 0, 1, "R14 q0 001");
    put(16'h6000, 0, 1, "R14 q0 011");
    put(16'h8000, 0, 1, "R14 q0 100");
    put(16'hA000, 0, 1, "R14 q0 101");
    put(16'hE000, 0, 1, "R14 q0 111");
    put(16'h2002, 0, 1, "R14 q2 001");
    put(16'h6002, 0, 1, "R14 q2 011");
    put(16'hA002, 0, 1, "R14 q2 101");
    put(16'hE002, 0, 1, "R14 q2 111");

    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle input after reset is the all-zero halfword
    @(negedge clk);
    total++;
    if (ill_out !== 1'b1 || w_out !== 32'h0) begin
      bad++;
      $display("FAIL R1 idle: got ill=%0b w=%08h exp ill=1 w=00000000", ill_out, w_out);
    end
    while (q_c.size() > 0) begin
      logic [15:0] c;
      logic [31:0] ew;
      bit          ei;
      string       t;
      c = q_c.pop_front(); ew = q_w.pop_front(); ei = q_i.pop_front(); t = q_t.pop_front();
      @(negedge clk);
      c_in = c;
      @(posedge clk);
      total++;
      if (ill_out !== ei || w_out !== ew) begin
        bad++;
        $display("FAIL %s: c=%04h got ill=%0b w=%08h exp ill=%0b w=%08h",
                 t, c, ill_out, w_out, ei, ew);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule